// File: doc/BRIEF.md
# Three-Channel Compare/Capture Timer

This block holds three independent 16-bit up-counters, each paired with a set of general registers. Each general register acts either as a compare register or as a capture register. Channel 0 has four general registers (A, B, C, D). Channels 1 and 2 have two each (A, B). A shared start register runs or halts each counter. Each channel drives one compare output pin and watches one capture input pin.

Software reaches every register through a simple word bus. Reads are combinational from `bus_addr`. Writes take effect on the rising clock edge while `bus_wr` is high.

The address is split into two parts:
- `bus_addr[4:3]` selects channel 0, 1 or 2. The value 3 selects the global space.
- `bus_addr[2:0]` selects a register inside the channel: 0 control, 1 I/O control, 2 status, 3 counter, 4..7 general registers A..D.

The start register sits at address 0x18.

When buffer mode is on, channel 0 pairs its general registers in fixed pairs: C shadows A and D shadows B. This gives glitch-free compare reloads and a two-deep capture history.

Top module: `mtim_top`

## Requirements
- R1: After reset, every counter reads 0x0000, every general register reads 0xFFFF, the start register reads 0 and all three compare pins are low.
- R2: A channel's counter advances by exactly one per clock while its start bit is 1, and holds its value while the bit is 0.
- R3: A write to a counter or to a general register takes effect only when both byte enables are 1. With `bus_be` at 01 or 10, the register keeps its old value.
- R4: When a running counter passes from 0xFFFF to 0x0000, status bit 0 (overflow) goes to 1. Writing 0 to that bit clears it, and writing 1 leaves it unchanged.
- R5: The I/O control field of general register k lies in bits [3k+2:3k]. Bit 2 of the field is 0 for compare mode, and bits 1:0 select the action: 00 none, 01 drive low, 10 drive high, 11 toggle. While the channel runs, a counter value equal to a compare register applies that action to the pin at the next clock edge.
- R6: When several compare registers of one channel match in the same cycle, their actions are applied in ascending register order, and the last one sets the final level.
- R7: While a channel's start bit is 0, its compare pin keeps its level, including the level left by a compare match that happened just before the stop.
- R8: Bit 15 of the I/O control register is the initial pin level. Writing the I/O control register while the channel is stopped puts that level on the pin at the next edge. The same write made while the channel runs leaves the pin to the compare logic.
- R9: A field with bit 2 set puts register k in capture mode. Bits 1:0 of the field select the edge: 01 rising, 10 falling, 11 both. On a selected edge of the capture input, seen against its level in the previous cycle, the register takes the counter value of that cycle.
- R10: With channel 0 control bit 0 set (buffer mode), a capture into A first moves the old A value into C, and a capture into B first moves the old B value into D.
- R11: In buffer mode, a compare match on channel 0 register A loads A from C, and a match on B loads B from D.
- R12: The start register at address 0x18 keeps one run bit per channel in bits 2:0, where bit n runs channel n. Bits 15:3 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Word address: channel in [4:3], register in [2:0] |
| bus_be | input | 2 | Byte enables (bit 1 upper byte, bit 0 lower byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| cap_in | input | 3 | Capture input, one per channel |
| cmp_out | output | 3 | Compare output pin, one per channel |

## Verification
The embedded properties assume that the capture inputs and bus signals are synchronous to `clk` and stable around the rising edge. They also assume that a counter load and a start-bit change are ordinary bus writes made while reset is low.

The stimulus keeps to these assumptions. It changes `cap_in` and every bus signal only at falling edges and holds each write for exactly one rising edge. It runs a channel for a known number of edges by bracketing writes to the start register, and it preloads counters while they are stopped, so each match and capture value is predictable to the cycle.

// File: rtl/mtim_pkg.sv
package mtim_pkg;

    localparam int DW       = 16;
    localparam int NCH      = 3;
    localparam int MAXGR    = 4;
    localparam int OFFW     = 3;
    localparam int CHW      = 2;
    localparam int AW       = CHW + OFFW;
    localparam int NSLOT    = 1 << OFFW;
    localparam int FLDW     = 3;
    localparam int INIT_BIT = 15;

    localparam logic [OFFW-1:0] OFF_CTRL = 3'd0;
    localparam logic [OFFW-1:0] OFF_IOC  = 3'd1;
    localparam logic [OFFW-1:0] OFF_STAT = 3'd2;
    localparam logic [OFFW-1:0] OFF_CNT  = 3'd3;
    localparam int              GR_BASE  = 4;

    localparam logic [CHW-1:0]  CH_GLOBAL = 2'd3;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_TOG  = 2'b11
    } act_e;

    // Per-register I/O field: cap=1 capture mode, act = edge select in capture mode
    typedef struct packed {
        logic cap;
        act_e act;
    } iofld_t;

    typedef struct packed {
        logic [MAXGR-1:0] gr;
        logic             cnt;
        logic             stat;
        logic             ioc;
        logic             ctrl;
    } wsel_t;

    function automatic int gr_count(input int ch);
        return (ch == 0) ? MAXGR : 2;
    endfunction

    function automatic logic apply_act(input logic cur, input act_e a);
        logic r;
        case (a)
            ACT_LOW:  r = 1'b0;
            ACT_HIGH: r = 1'b1;
            ACT_TOG:  r = ~cur;
            default:  r = cur;
        endcase
        return r;
    endfunction

    function automatic logic [DW-1:0] be_merge(input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] new_v,
                                               input logic [1:0]    be);
        logic [DW-1:0] r;
        r = old_v;
        if (be[0]) r[DW/2-1:0]  = new_v[DW/2-1:0];
        if (be[1]) r[DW-1:DW/2] = new_v[DW-1:DW/2];
        return r;
    endfunction

endpackage

// File: rtl/mtim_counter.sv
module mtim_counter
    import mtim_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (run)  cnt <= cnt + 1'b1;
    end

    assign wrap = run & ~load & (cnt == TOP);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(!run && !load)) |-> (cnt == $past(cnt)));   // R2

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(run && !load)) |-> (cnt == W'($past(cnt) + 1'b1)));   // R2

endmodule

// File: rtl/mtim_regif.sv
module mtim_regif
    import mtim_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             bus_wr,
    input  logic [AW-1:0]                    bus_addr,
    input  logic                             be_lo,
    input  logic [N-1:0]                     start_wd,
    input  logic [N-1:0][NSLOT-1:0][DW-1:0]  ch_rd,
    output logic [N-1:0]                     start_q,
    output wsel_t [N-1:0]                    wsel,
    output logic [DW-1:0]                    bus_rdata
);

    logic [CHW-1:0]  ch_idx;
    logic [OFFW-1:0] off;
    logic            gl_wr;

    assign ch_idx = bus_addr[AW-1:OFFW];
    assign off    = bus_addr[OFFW-1:0];
    assign gl_wr  = bus_wr && (ch_idx == CH_GLOBAL) && (off == '0);

    always_comb begin
        for (int i = 0; i < N; i++) begin
            wsel[i] = '0;
            if (bus_wr && (ch_idx == CHW'(i))) begin
                case (off)
                    OFF_CTRL: wsel[i].ctrl = 1'b1;
                    OFF_IOC:  wsel[i].ioc  = 1'b1;
                    OFF_STAT: wsel[i].stat = 1'b1;
                    OFF_CNT:  wsel[i].cnt  = 1'b1;
                    default:  wsel[i].gr[off[1:0]] = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                start_q <= '0;
        else if (gl_wr && be_lo) start_q <= start_wd;
    end

    always_comb begin
        bus_rdata = '0;
        if (ch_idx == CH_GLOBAL) begin
            if (off == '0) bus_rdata = DW'(start_q);
        end else if (ch_idx < CHW'(N)) begin
            bus_rdata = ch_rd[ch_idx][off];
        end
    end

    AST_WSEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wsel));   // R12

    AST_START_LOCAL: assert property (@(posedge clk) disable iff (rst)
        $past(!gl_wr) |-> $stable(start_q));   // R12

endmodule

// File: rtl/mtim_chan.sv
module mtim_chan
    import mtim_pkg::*;
#(
    parameter int N_GR    = 2,
    parameter bit HAS_BUF = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         run,
    input  wsel_t                        wsel,
    input  logic [DW-1:0]                wdata,
    input  logic [1:0]                   be,
    input  logic                         cap_in,
    output logic                         pin,
    output logic [NSLOT-1:0][DW-1:0]     rd
);

    localparam bit            BUF_CAP  = HAS_BUF && (N_GR == MAXGR);
    localparam int            NPAIR    = N_GR / 2;
    localparam logic [DW-1:0] IOC_MASK = DW'((1 << (FLDW * N_GR)) - 1) | (DW'(1) << INIT_BIT);

    logic            full_wr;
    logic [DW-1:0]   cnt;
    logic            wrap;
    logic            buf_en;
    logic            buf_on;
    logic [DW-1:0]   ioc_q;
    logic [DW-1:0]   ioc_new;
    logic            ioc_wr;
    logic            ovf;
    logic            cap_prev;
    logic            rise;
    logic            fall;
    logic            pin_d;
    iofld_t          fld     [N_GR];
    logic [DW-1:0]   gr_q    [N_GR];
    logic [N_GR-1:0] active;
    logic [N_GR-1:0] cap_hit;
    logic [N_GR-1:0] cmp_hit;

    assign full_wr = &be;

    mtim_counter #(.W(DW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .load     (wsel.cnt & full_wr),
        .load_val (wdata),
        .cnt      (cnt),
        .wrap     (wrap)
    );

    // control: bit 0 buffer mode (effective only where pairs exist)
    always_ff @(posedge clk) begin
        if (rst)                      buf_en <= 1'b0;
        else if (wsel.ctrl && be[0])  buf_en <= wdata[0];
    end
    assign buf_on = BUF_CAP & buf_en;

    assign ioc_new = be_merge(ioc_q, wdata, be) & IOC_MASK;
    assign ioc_wr  = wsel.ioc & (|be);

    always_ff @(posedge clk) begin
        if (rst)         ioc_q <= '0;
        else if (ioc_wr) ioc_q <= ioc_new;
    end

    always_ff @(posedge clk) begin
        if (rst) cap_prev <= 1'b0;
        else     cap_prev <= cap_in;
    end
    assign rise = cap_in & ~cap_prev;
    assign fall = ~cap_in & cap_prev;

    for (genvar k = 0; k < N_GR; k++) begin : g_gr
        assign fld[k]     = iofld_t'(ioc_q[FLDW*k +: FLDW]);
        assign active[k]  = !(buf_on && (k >= NPAIR));
        assign cap_hit[k] = active[k] & fld[k].cap &
                            ((fld[k].act[0] & rise) | (fld[k].act[1] & fall));
        assign cmp_hit[k] = active[k] & ~fld[k].cap & run & (cnt == gr_q[k]);

        if (BUF_CAP && (k < NPAIR)) begin : g_main
            always_ff @(posedge clk) begin
                if (rst)                        gr_q[k] <= '1;
                else if (wsel.gr[k] && full_wr) gr_q[k] <= wdata;
                else if (cap_hit[k])            gr_q[k] <= cnt;
                else if (buf_on && cmp_hit[k])  gr_q[k] <= gr_q[k+NPAIR];
            end
        end else if (BUF_CAP) begin : g_shadow
            always_ff @(posedge clk) begin
                if (rst)                                gr_q[k] <= '1;
                else if (wsel.gr[k] && full_wr)         gr_q[k] <= wdata;
                else if (buf_on && cap_hit[k-NPAIR])    gr_q[k] <= gr_q[k-NPAIR];
                else if (cap_hit[k])                    gr_q[k] <= cnt;
            end

            AST_BUF_SHIFT: assert property (@(posedge clk) disable iff (rst)
                $past(buf_on && cap_hit[k-NPAIR] && !(wsel.gr[k] && full_wr))
                |-> (gr_q[k] == $past(gr_q[k-NPAIR])));   // R10
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)                        gr_q[k] <= '1;
                else if (wsel.gr[k] && full_wr) gr_q[k] <= wdata;
                else if (cap_hit[k])            gr_q[k] <= cnt;
            end
        end
    end

    always_comb begin
        pin_d = pin;
        for (int k = 0; k < N_GR; k++) begin
            if (cmp_hit[k]) pin_d = apply_act(pin_d, fld[k].act);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  pin <= 1'b0;
        else if (ioc_wr && !run)  pin <= ioc_new[INIT_BIT];
        else                      pin <= pin_d;
    end

    always_ff @(posedge clk) begin
        if (rst)                                ovf <= 1'b0;
        else if (wrap)                          ovf <= 1'b1;
        else if (wsel.stat && be[0] && !wdata[0]) ovf <= 1'b0;
    end

    always_comb begin
        rd           = '0;
        rd[OFF_CTRL] = DW'(buf_en);
        rd[OFF_IOC]  = ioc_q;
        rd[OFF_STAT] = DW'(ovf);
        rd[OFF_CNT]  = cnt;
        for (int k = 0; k < N_GR; k++) rd[GR_BASE+k] = gr_q[k];
    end

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(wrap)) |-> ovf);   // R4

    AST_PIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(!run && !ioc_wr)) |-> (pin == $past(pin)));   // R7

    AST_PIN_INIT: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(ioc_wr && !run)) |-> (pin == $past(wdata[INIT_BIT] & be[1] | ioc_q[INIT_BIT] & ~be[1])));   // R8

    AST_NARROW_CNT: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(wsel.cnt && !full_wr && !run)) |-> (cnt == $past(cnt)));   // R3

endmodule

// File: rtl/mtim_top.sv
module mtim_top
    import mtim_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_wr,
    input  logic [4:0]     bus_addr,
    input  logic [1:0]     bus_be,
    input  logic [15:0]    bus_wdata,
    output logic [15:0]    bus_rdata,
    input  logic [2:0]     cap_in,
    output logic [2:0]     cmp_out
);

    logic [NCH-1:0]                    start_q;
    wsel_t [NCH-1:0]                   wsel;
    logic [NCH-1:0][NSLOT-1:0][DW-1:0] ch_rd;

    mtim_regif #(.N(NCH)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .be_lo     (bus_be[0]),
        .start_wd  (bus_wdata[NCH-1:0]),
        .ch_rd     (ch_rd),
        .start_q   (start_q),
        .wsel      (wsel),
        .bus_rdata (bus_rdata)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        mtim_chan #(
            .N_GR    (gr_count(i)),
            .HAS_BUF (i == 0)
        ) u_chan (
            .clk    (clk),
            .rst    (rst),
            .run    (start_q[i]),
            .wsel   (wsel[i]),
            .wdata  (bus_wdata),
            .be     (bus_be),
            .cap_in (cap_in[i]),
            .pin    (cmp_out[i]),
            .rd     (ch_rd[i])
        );
    end

endmodule

// File: tb/mtim_top_tb.sv
module mtim_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [4:0]  bus_addr;
    logic [1:0]  bus_be;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [2:0]  cap_in;
    logic [2:0]  cmp_out;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    mtim_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap_in    (cap_in),
        .cmp_out   (cmp_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            failures = failures + 1;
            $display("FAIL watchdog act=%0d exp<=20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    typedef struct packed {
        logic        is_rd;
        logic [4:0]  addr;
        logic [15:0] data;
        logic [1:0]  be;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 5'h03, 16'h0000, 2'b11, 4'd1},   // R1 ch0 counter
        '{1'b1, 5'h04, 16'hFFFF, 2'b11, 4'd1},   // R1 ch0 GR A
        '{1'b1, 5'h0D, 16'hFFFF, 2'b11, 4'd1},   // R1 ch1 GR B
        '{1'b1, 5'h18, 16'h0000, 2'b11, 4'd1},   // R1 start register
        '{1'b0, 5'h04, 16'h1234, 2'b01, 4'd3},
        '{1'b1, 5'h04, 16'hFFFF, 2'b11, 4'd3},   // R3 low-byte write ignored
        '{1'b0, 5'h04, 16'h1234, 2'b10, 4'd3},
        '{1'b1, 5'h04, 16'hFFFF, 2'b11, 4'd3},   // R3 high-byte write ignored
        '{1'b0, 5'h04, 16'h1234, 2'b11, 4'd3},
        '{1'b1, 5'h04, 16'h1234, 2'b11, 4'd3},   // R3 full write
        '{1'b0, 5'h0B, 16'h0055, 2'b01, 4'd3},
        '{1'b1, 5'h0B, 16'h0000, 2'b11, 4'd3},   // R3 counter narrow write
        '{1'b0, 5'h0B, 16'hFFFE, 2'b11, 4'd3},
        '{1'b1, 5'h0B, 16'hFFFE, 2'b11, 4'd3},   // R3 counter full write
        '{1'b0, 5'h18, 16'hFFF8, 2'b11, 4'd12},
        '{1'b1, 5'h18, 16'h0000, 2'b11, 4'd12}   // R12 reserved bits read 0
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic [1:0] b);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = b;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [15:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    // run the channels in mask for exactly two counting edges
    task automatic run2(input logic [15:0] mask);
        wr(5'h18, mask, 2'b11);
        wr(5'h18, 16'h0000, 2'b11);
    endtask

    task automatic cap_set(input int idx, input logic v);
        @(negedge clk);
        cap_in[idx] = v;
        @(negedge clk);
    endtask

    task automatic pin_chk(input int idx, input logic exp, input string req);
        @(negedge clk);
        chk(req, 16'(cmp_out[idx]), 16'(exp));
    endtask

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0; cap_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        chk("R1 pins", 16'(cmp_out), 16'h0000);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_rd) rd_chk(VEC[i].addr, VEC[i].data, $sformatf("R%0d vec%0d", VEC[i].req, i));
            else              wr(VEC[i].addr, VEC[i].data, VEC[i].be);
        end

        // R12 + R2: start bits 2:0 readable; run ch1 from FFFE
        wr(5'h18, 16'h0005, 2'b11);
        rd_chk(5'h18, 16'h0005, "R12 start bits");
        wr(5'h18, 16'h0000, 2'b11);
        wr(5'h03, 16'h0000, 2'b11);
        wr(5'h13, 16'h0000, 2'b11);
        run2(16'h0002);
        rd_chk(5'h0B, 16'h0000, "R4 wrap to zero");
        rd_chk(5'h0A, 16'h0001, "R4 overflow set");
        rd_chk(5'h03, 16'h0000, "R2 stopped ch0 holds");
        repeat (3) @(negedge clk);
        rd_chk(5'h0B, 16'h0000, "R2 hold after stop");
        wr(5'h0A, 16'h0001, 2'b11);
        rd_chk(5'h0A, 16'h0001, "R4 write 1 no effect");
        wr(5'h0A, 16'h0000, 2'b11);
        rd_chk(5'h0A, 16'h0000, "R4 write 0 clears");
        wr(5'h0B, 16'h0100, 2'b11);
        run2(16'h0002);
        rd_chk(5'h0B, 16'h0102, "R2 two steps");

        // R5: ch2 toggle on A match
        wr(5'h13, 16'h0010, 2'b11);
        wr(5'h14, 16'h0011, 2'b11);
        wr(5'h11, 16'h0003, 2'b11);
        pin_chk(2, 1'b0, "R8 init level 0");
        run2(16'h0004);
        pin_chk(2, 1'b1, "R5 toggle on match");
        rd_chk(5'h13, 16'h0012, "R2 ch2 count");
        repeat (4) @(negedge clk);
        pin_chk(2, 1'b1, "R7 level kept while stopped");

        // R6: A high then B toggle, same match cycle
        wr(5'h13, 16'h0020, 2'b11);
        wr(5'h14, 16'h0021, 2'b11);
        wr(5'h15, 16'h0021, 2'b11);
        wr(5'h11, 16'h801A, 2'b11);
        pin_chk(2, 1'b1, "R8 init level 1");
        run2(16'h0004);
        pin_chk(2, 1'b0, "R6 ascending order");

        // R8: ioc write while running leaves pin alone
        wr(5'h18, 16'h0004, 2'b11);
        wr(5'h11, 16'h8000, 2'b11);
        wr(5'h18, 16'h0000, 2'b11);
        pin_chk(2, 1'b0, "R8 running write no force");
        wr(5'h11, 16'h8000, 2'b11);
        pin_chk(2, 1'b1, "R8 stopped write forces");

        // R9: ch1 A rising, B falling
        wr(5'h0B, 16'h0100, 2'b11);
        wr(5'h09, 16'h0035, 2'b11);
        cap_set(1, 1'b1);
        rd_chk(5'h0C, 16'h0100, "R9 rising capture A");
        rd_chk(5'h0D, 16'hFFFF, "R9 B ignores rising");
        wr(5'h0B, 16'h0200, 2'b11);
        cap_set(1, 1'b0);
        rd_chk(5'h0D, 16'h0200, "R9 falling capture B");
        rd_chk(5'h0C, 16'h0100, "R9 A ignores falling");

        // R10: ch0 buffered capture, both edges
        wr(5'h00, 16'h0001, 2'b11);
        wr(5'h01, 16'h0007, 2'b11);
        wr(5'h03, 16'h0300, 2'b11);
        cap_set(0, 1'b1);
        rd_chk(5'h04, 16'h0300, "R10 A captured");
        rd_chk(5'h06, 16'h1234, "R10 old A to C");
        wr(5'h03, 16'h0400, 2'b11);
        cap_set(0, 1'b0);
        rd_chk(5'h04, 16'h0400, "R10 A second capture");
        rd_chk(5'h06, 16'h0300, "R10 C history");

        // R11: ch0 buffered compare reload
        wr(5'h01, 16'h0003, 2'b11);
        wr(5'h06, 16'h0600, 2'b11);
        wr(5'h04, 16'h0501, 2'b11);
        wr(5'h03, 16'h0500, 2'b11);
        run2(16'h0001);
        rd_chk(5'h04, 16'h0600, "R11 A reloaded from C");
        pin_chk(0, 1'b1, "R5 ch0 toggle");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule